// File: doc/BRIEF.md
# Serial Flash Status Register Write-Protect Controller

This block holds the two status bytes of a serial flash device and decides, in the cycle a command arrives, whether that command may run. An upstream SPI decoder hands it one decoded command per cycle, along with a flag that says whether chip select rose on a byte boundary. The block also receives the write-protect pin level and a completion pulse from the program/erase timing logic. Each command is answered in the same cycle with exactly one of accept or reject. Accepted commands update the write-enable latch, the busy flag, the suspend flag, the power-down state and the protection fields.

The protection fields are non-volatile in silicon. Here they are registers that load a parameterised power-on value whenever reset is asserted. Reset therefore stands for a full power cycle, and a power-on value in the temporary lock-down mode comes up in the unprotected mode. Status writes are allowed or refused through a mode table that combines the two status-protect bits with the write-protect pin. When quad mode is enabled, the pin is read as inactive.

Top module: `sr_wp_ctrl`

## Requirements
- R1: After reset, status bits 9..2 hold the POR_NV parameter value, and BUSY (bit 0), WEL (bit 1) and SUS (bit 15) read 0. A power-on value with SRP1=1, SRP0=0 (bits 8,7 = 10) loads as 00.
- R2: Command code 1 (write enable) sets WEL and code 2 (write disable) clears it; the effect is visible on the cycle after acceptance.
- R3: Status write (code 4), program (code 5) and erase (code 6) are rejected while WEL=0. When accepted, each sets BUSY on the next cycle.
- R4: A `job_done` pulse while BUSY=1 clears both BUSY and WEL on the next cycle.
- R5: An accepted status write copies `sr_wdata` bits 9..2 into QE (9), SRP1 (8), SRP0 (7), SEC (6), TB (5) and BP2..BP0 (4..2), and leaves all other bits unchanged. With SRP1,SRP0=00 it is accepted whenever WEL=1, at any pin level.
- R6: With SRP1,SRP0=01, a status write is rejected while `wp_n_i` is low and QE=0. It is allowed while `wp_n_i` is high, or while QE=1.
- R7: With SRP1=1 (modes 10 and 11), every status write is rejected. After a power cycle, mode 10 no longer applies.
- R8: While BUSY=1, only read status (code 3) and erase suspend (code 7) can be accepted.
- R9: Suspend (code 7) is accepted only while an erase is busy: it sets SUS and clears BUSY. Resume (code 8) is accepted only when SUS=1 and BUSY=0: it clears SUS and sets BUSY.
- R10: Codes 1, 2, 4, 5 and 6 are rejected with no effect when `cmd_full_byte` is 0.
- R11: After an accepted power-down (code 9), every command except release (code 10) is rejected; an accepted release restores normal decoding.
- R12: Every `cmd_vld` cycle gives exactly one of `cmd_ack` and `cmd_nak`, neither is raised without `cmd_vld`, and status bits 14..10 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-cycle reset, asynchronous assert |
| cmd_vld | input | 1 | A decoded command is present this cycle |
| cmd_code | input | 4 | Decoded command code |
| cmd_full_byte | input | 1 | Chip select rose on a byte boundary |
| sr_wdata | input | 16 | Status write data |
| job_done | input | 1 | Program/erase/status-write cycle finished |
| wp_n_i | input | 1 | Write-protect pin level, active low |
| sr_out | output | 16 | Status bytes, bit 15 down to bit 0 |
| cmd_ack | output | 1 | Command accepted |
| cmd_nak | output | 1 | Command rejected |

## Verification
The bench builds the controller with POR_NV = 16'h011C. The block therefore powers up with all three block-protect bits set and the power-on lock-down mode demoted, so the R1 load path and its demotion are visible on the first status read. QE_GATES_WP stays at 1, which makes the quad-mode override of the pin reachable in the mode-01 checks. The random phase then visits suspend during completion, lock-down writes and power-down from arbitrary states.

// File: rtl/sr_wp_pkg.sv
package sr_wp_pkg;
  typedef enum logic [3:0] {
    OP_NONE   = 4'd0,
    OP_WREN   = 4'd1,
    OP_WRDI   = 4'd2,
    OP_RDSR   = 4'd3,
    OP_WRSR   = 4'd4,
    OP_PROG   = 4'd5,
    OP_ERASE  = 4'd6,
    OP_SUSP   = 4'd7,
    OP_RESUME = 4'd8,
    OP_PWRDN  = 4'd9,
    OP_RELPD  = 4'd10
  } sr_op_e;

  localparam int SR_W     = 16;
  localparam int B_BUSY   = 0;
  localparam int B_WEL    = 1;
  localparam int B_SRP0   = 7;
  localparam int B_SRP1   = 8;
  localparam int B_QE     = 9;
  localparam int B_SUS    = 15;
  localparam logic [SR_W-1:0] NV_MASK = 16'h03FC;
endpackage

// File: rtl/sr_wp_gate.sv
module sr_wp_gate
  import sr_wp_pkg::*;
#(
  parameter bit QE_GATES_WP = 1'b1
) (
  input  logic       vld,
  input  logic [3:0] code,
  input  logic       full_byte,
  input  logic       wp_n,
  input  logic       busy,
  input  logic       wel,
  input  logic       sus,
  input  logic       pd,
  input  logic       ers,
  input  logic [1:0] srp,
  input  logic       qe,
  output logic       ack,
  output logic       nak
);
  sr_op_e op;
  logic   wp_eff;
  logic   srp_ok;
  logic   wr_class;
  logic   ok;

  assign op = sr_op_e'(code);

  generate
    if (QE_GATES_WP) begin : g_qe_gate
      assign wp_eff = wp_n | qe;
    end else begin : g_pin_only
      assign wp_eff = wp_n;
    end
  endgenerate

  assign srp_ok   = (srp == 2'b00) || ((srp == 2'b01) && wp_eff);
  assign wr_class = (op == OP_WREN) || (op == OP_WRDI) || (op == OP_WRSR) ||
                    (op == OP_PROG) || (op == OP_ERASE);

  always_comb begin
    ok = 1'b0;
    if (pd) begin
      ok = (op == OP_RELPD);
    end else if (wr_class && !full_byte) begin
      ok = 1'b0;
    end else if (busy) begin
      ok = (op == OP_RDSR) || ((op == OP_SUSP) && ers);
    end else begin
      unique case (op)
        OP_WREN, OP_WRDI, OP_RDSR, OP_PWRDN: ok = 1'b1;
        OP_WRSR:           ok = wel && srp_ok;
        OP_PROG, OP_ERASE: ok = wel;
        OP_RESUME:         ok = sus;
        default:           ok = 1'b0;
      endcase
    end
  end

  assign ack = vld && ok;
  assign nak = vld && !ok;
endmodule

// File: rtl/sr_wp_state.sv
module sr_wp_state
  import sr_wp_pkg::*;
#(
  parameter logic [SR_W-1:0] POR_NV = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ack,
  input  logic [3:0]      code,
  input  logic [SR_W-1:0] wdata,
  input  logic            job_done,
  output logic [SR_W-1:0] nv_q,
  output logic            busy_q,
  output logic            wel_q,
  output logic            sus_q,
  output logic            pd_q,
  output logic            ers_q
);
  localparam logic [SR_W-1:0] POR_M    = POR_NV & NV_MASK;
  localparam logic [SR_W-1:0] LOCK_BITS = SR_W'(1) << B_SRP1 | SR_W'(1) << B_SRP0;
  localparam logic [SR_W-1:0] POR_EFF  =
    (POR_M[B_SRP1] && !POR_M[B_SRP0]) ? (POR_M & ~LOCK_BITS) : POR_M;

  sr_op_e          op;
  logic            fin;
  logic [SR_W-1:0] nv_d;
  logic            busy_d, wel_d, sus_d, pd_d, ers_d;
  logic            upd;

  assign op  = sr_op_e'(code);
  assign fin = job_done && busy_q;
  assign upd = ack || fin;

  always_comb begin
    nv_d   = nv_q;
    busy_d = busy_q;
    wel_d  = wel_q;
    sus_d  = sus_q;
    pd_d   = pd_q;
    ers_d  = ers_q;
    if (fin) begin
      busy_d = 1'b0;
      wel_d  = 1'b0;
      ers_d  = 1'b0;
    end
    if (ack) begin
      unique case (op)
        OP_WREN:   wel_d = 1'b1;
        OP_WRDI:   wel_d = 1'b0;
        OP_WRSR: begin
          nv_d   = (nv_q & ~NV_MASK) | (wdata & NV_MASK);
          busy_d = 1'b1;
        end
        OP_PROG:   busy_d = 1'b1;
        OP_ERASE: begin
          busy_d = 1'b1;
          ers_d  = 1'b1;
        end
        OP_SUSP: begin
          sus_d  = 1'b1;
          busy_d = 1'b0;
          ers_d  = 1'b0;
        end
        OP_RESUME: begin
          sus_d  = 1'b0;
          busy_d = 1'b1;
          ers_d  = 1'b1;
        end
        OP_PWRDN:  pd_d = 1'b1;
        OP_RELPD:  pd_d = 1'b0;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_q   <= POR_EFF;
      busy_q <= 1'b0;
      wel_q  <= 1'b0;
      sus_q  <= 1'b0;
      pd_q   <= 1'b0;
      ers_q  <= 1'b0;
    end else if (upd) begin
      nv_q   <= nv_d;
      busy_q <= busy_d;
      wel_q  <= wel_d;
      sus_q  <= sus_d;
      pd_q   <= pd_d;
      ers_q  <= ers_d;
    end
  end
endmodule

// File: rtl/sr_wp_ctrl.sv
module sr_wp_ctrl
  import sr_wp_pkg::*;
#(
  parameter logic [15:0] POR_NV      = 16'h0000,
  parameter bit          QE_GATES_WP = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_vld,
  input  logic [3:0]  cmd_code,
  input  logic        cmd_full_byte,
  input  logic [15:0] sr_wdata,
  input  logic        job_done,
  input  logic        wp_n_i,
  output logic [15:0] sr_out,
  output logic        cmd_ack,
  output logic        cmd_nak
);
  logic [1:0]      rst_pipe;
  logic            rst_sync_n;
  logic [SR_W-1:0] nv_q;
  logic            busy_q, wel_q, sus_q, pd_q, ers_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  sr_wp_gate #(.QE_GATES_WP(QE_GATES_WP)) u_gate (
    .vld       (cmd_vld),
    .code      (cmd_code),
    .full_byte (cmd_full_byte),
    .wp_n      (wp_n_i),
    .busy      (busy_q),
    .wel       (wel_q),
    .sus       (sus_q),
    .pd        (pd_q),
    .ers       (ers_q),
    .srp       ({nv_q[B_SRP1], nv_q[B_SRP0]}),
    .qe        (nv_q[B_QE]),
    .ack       (cmd_ack),
    .nak       (cmd_nak)
  );

  sr_wp_state #(.POR_NV(POR_NV)) u_state (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ack      (cmd_ack),
    .code     (cmd_code),
    .wdata    (sr_wdata),
    .job_done (job_done),
    .nv_q     (nv_q),
    .busy_q   (busy_q),
    .wel_q    (wel_q),
    .sus_q    (sus_q),
    .pd_q     (pd_q),
    .ers_q    (ers_q)
  );

  always_comb begin
    sr_out         = nv_q & NV_MASK;
    sr_out[B_SUS]  = sus_q;
    sr_out[B_WEL]  = wel_q;
    sr_out[B_BUSY] = busy_q;
  end
endmodule

// File: rtl/sr_wp_chk.sv
module sr_wp_chk
  import sr_wp_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_vld,
  input logic [3:0]  cmd_code,
  input logic        cmd_full_byte,
  input logic        job_done,
  input logic [15:0] sr_out,
  input logic        cmd_ack,
  input logic        cmd_nak,
  input logic        pd
);
  logic wr_cls;
  logic start_cls;
  assign wr_cls    = (cmd_code == OP_WREN) || (cmd_code == OP_WRDI) || (cmd_code == OP_WRSR) ||
                     (cmd_code == OP_PROG) || (cmd_code == OP_ERASE);
  assign start_cls = (cmd_code == OP_WRSR) || (cmd_code == OP_PROG) || (cmd_code == OP_ERASE);

  // R12
  one_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |-> (cmd_ack ^ cmd_nak));
  // R12
  idle_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_vld |-> (!cmd_ack && !cmd_nak));
  // R12
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_out[14:10] == 5'd0);
  // R3
  no_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && start_cls && !sr_out[B_WEL]) |-> !cmd_ack);
  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ack && start_cls) |=> sr_out[B_BUSY]);
  // R4
  done_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (job_done && sr_out[B_BUSY]) |=> (!sr_out[B_BUSY] && !sr_out[B_WEL]));
  // R7
  lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_code == OP_WRSR && sr_out[B_SRP1]) |-> !cmd_ack);
  // R8
  busy_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && sr_out[B_BUSY] && cmd_code != OP_RDSR && cmd_code != OP_SUSP) |-> !cmd_ack);
  // R10
  partial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && wr_cls && !cmd_full_byte) |-> !cmd_ack);
  // R11
  pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd && cmd_vld && cmd_code != OP_RELPD) |-> !cmd_ack);
endmodule

bind sr_wp_ctrl sr_wp_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .cmd_vld       (cmd_vld),
  .cmd_code      (cmd_code),
  .cmd_full_byte (cmd_full_byte),
  .job_done      (job_done),
  .sr_out        (sr_out),
  .cmd_ack       (cmd_ack),
  .cmd_nak       (cmd_nak),
  .pd            (pd_q)
);

// File: tb/sr_wp_ctrl_tb.sv
module sr_wp_ctrl_tb;
  localparam logic [15:0] POR = 16'h011C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_vld, cmd_full_byte, job_done, wp_n_i;
  logic [3:0]  cmd_code;
  logic [15:0] sr_wdata;
  logic [15:0] sr_out;
  logic        cmd_ack, cmd_nak;

  int n_run  = 0;
  int n_fail = 0;

  // bench reference state
  logic [15:0] m_nv;
  logic        m_busy, m_wel, m_sus, m_pd, m_ers;

  always #10 clk = ~clk;

  sr_wp_ctrl #(.POR_NV(POR), .QE_GATES_WP(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_code(cmd_code),
    .cmd_full_byte(cmd_full_byte), .sr_wdata(sr_wdata), .job_done(job_done),
    .wp_n_i(wp_n_i), .sr_out(sr_out), .cmd_ack(cmd_ack), .cmd_nak(cmd_nak)
  );

  function automatic logic [15:0] m_status();
    logic [15:0] s;
    s = m_nv & 16'h03FC;
    s[15] = m_sus; s[1] = m_wel; s[0] = m_busy;
    return s;
  endfunction

  function automatic logic m_ok(input logic [3:0] c, input logic full, input logic wp);
    logic wrc, wpe, srpok;
    wrc   = (c == 1) || (c == 2) || (c == 4) || (c == 5) || (c == 6);
    wpe   = wp || m_nv[9];
    srpok = (m_nv[8:7] == 2'b00) || ((m_nv[8:7] == 2'b01) && wpe);
    if (m_pd) return (c == 10);
    if (wrc && !full) return 1'b0;
    if (m_busy) return (c == 3) || ((c == 7) && m_ers);
    case (c)
      1, 2, 3, 9: return 1'b1;
      4:          return m_wel && srpok;
      5, 6:       return m_wel;
      8:          return m_sus;
      default:    return 1'b0;
    endcase
  endfunction

  task automatic m_reset();
    m_nv = POR & 16'h03FC;
    if (m_nv[8:7] == 2'b10) m_nv[8:7] = 2'b00;
    m_busy = 0; m_wel = 0; m_sus = 0; m_pd = 0; m_ers = 0;
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input string req, input logic v, input logic [3:0] c, input logic full,
                     input logic [15:0] wd, input logic dn, input logic wp);
    logic a;
    @(negedge clk);
    cmd_vld = v; cmd_code = c; cmd_full_byte = full; sr_wdata = wd; job_done = dn; wp_n_i = wp;
    #2;
    a = v && m_ok(c, full, wp);
    check(req, {14'd0, cmd_ack, cmd_nak}, {14'd0, a, v && !a});
    @(posedge clk);
    #1;
    if (dn && m_busy) begin m_busy = 0; m_wel = 0; m_ers = 0; end
    if (a) begin
      case (c)
        1: m_wel = 1;
        2: m_wel = 0;
        4: begin m_nv = (m_nv & ~16'h03FC) | (wd & 16'h03FC); m_busy = 1; end
        5: m_busy = 1;
        6: begin m_busy = 1; m_ers = 1; end
        7: begin m_sus = 1; m_busy = 0; m_ers = 0; end
        8: begin m_sus = 0; m_busy = 1; m_ers = 1; end
        9: m_pd = 1;
        10: m_pd = 0;
        default: ;
      endcase
    end
    check(req, sr_out, m_status());
  endtask

  task automatic cmd(input string req, input logic [3:0] c, input logic [15:0] wd = 16'h0,
                     input logic wp = 1'b1, input logic full = 1'b1);
    cyc(req, 1'b1, c, full, wd, 1'b0, wp);
  endtask

  task automatic finish_job(input string req);
    cyc(req, 1'b0, 4'd0, 1'b1, 16'h0, 1'b1, 1'b1);
  endtask

  task automatic power_cycle();
    @(negedge clk);
    rst_n = 1'b0; cmd_vld = 0; job_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    m_reset();
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_vld = 0; cmd_code = 0; cmd_full_byte = 1; sr_wdata = 0;
    job_done = 0; wp_n_i = 1;
    power_cycle();
    // R1 and R7: power-on value with lock-down mode comes up demoted
    check("R1", sr_out, 16'h001C);

    cmd("R3", 4'd4, 16'h0000);            // status write without WEL
    cmd("R3", 4'd5);                      // program without WEL
    cmd("R2", 4'd1);                      // write enable
    check("R2", sr_out, 16'h001E);
    cmd("R2", 4'd2);                      // write disable
    cmd("R2", 4'd1);
    cmd("R10", 4'd4, 16'h0000, 1'b1, 1'b0); // partial byte
    check("R10", sr_out, 16'h001E);
    cmd("R5", 4'd4, 16'hFC80);            // SRP0=1, others from mask only
    check("R5", sr_out, 16'h0083);
    cmd("R8", 4'd1);                      // write enable while busy
    cmd("R8", 4'd3);                      // read status while busy
    finish_job("R4");
    check("R4", sr_out, 16'h0080);

    // R6: mode 01
    cmd("R6", 4'd1);
    cmd("R6", 4'd4, 16'h0280, 1'b1);      // set QE with pin high
    finish_job("R6");
    cmd("R6", 4'd1);
    cmd("R6", 4'd4, 16'h0284, 1'b0);      // pin low but QE=1 overrides
    check("R6", sr_out, 16'h0287);
    finish_job("R6");
    cmd("R6", 4'd1);
    cmd("R6", 4'd4, 16'h0084, 1'b0);      // clear QE
    finish_job("R6");
    cmd("R6", 4'd1);
    cmd("R6", 4'd4, 16'h0000, 1'b0);      // pin low, QE=0: refused
    check("R6", sr_out, 16'h0086);
    cmd("R7", 4'd4, 16'h0100, 1'b1);      // enter mode 10
    finish_job("R7");
    cmd("R7", 4'd1);
    cmd("R7", 4'd4, 16'h0000, 1'b1);      // locked
    check("R7", sr_out, 16'h0102);

    // R9: suspend / resume
    cmd("R9", 4'd5);                      // program, WEL still 1
    cmd("R9", 4'd7);                      // suspend refused on program
    finish_job("R9");
    cmd("R9", 4'd1);
    cmd("R9", 4'd6);
    cmd("R9", 4'd7);
    check("R9", sr_out, 16'h8102);
    cmd("R9", 4'd8);
    check("R9", sr_out, 16'h0103);
    finish_job("R9");

    // R11: power-down
    cmd("R11", 4'd9);
    cmd("R11", 4'd1);
    cmd("R11", 4'd3);
    cmd("R11", 4'd10);
    cmd("R11", 4'd1);
    check("R11", sr_out, 16'h0102);

    power_cycle();
    check("R7", sr_out, 16'h001C);        // lock-down gone after power cycle
    cmd("R7", 4'd1);
    cmd("R7", 4'd4, 16'h0180);            // mode 11
    finish_job("R7");
    cmd("R7", 4'd1);
    cmd("R7", 4'd4, 16'h0000);
    check("R7", sr_out, 16'h0182);

    // R12: constrained random mix
    power_cycle();
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 600; i++) begin
      logic [3:0] c;
      c = 4'($urandom_range(0, 11));
      cyc("R12", ($urandom_range(0, 9) < 8), c, ($urandom_range(0, 9) != 0),
          16'($urandom), ($urandom_range(0, 9) < 3), 1'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule